// File: doc/BRIEF.md
# Performance Mode Clock Selector

This block keeps a 16-bit clock control register whose low three bits hold a performance mode. The mode sets the divide choices of several clock domains together: the processor, the interconnect peripherals, the fast-bus peripherals and the slow-bus peripherals. Every domain is described by a source bit (main 208 MHz PLL or always-on 13 MHz PLL) and a divide exponent, where the domain rate is the source rate divided by 2 to the power of the exponent. The block only selects ratios. It does not mux clocks and does not model the PLLs.

Software changes the mode in one of three ways. It can write the whole register, write only the mode field, or post a processor rate request in MHz, which the block rounds to a mode. A status word reports whether the main PLL is locked and whether the slow PLL is in use. In the lowest mode the main PLL is considered off. Once that mode is left, the lock bit stays low for a fixed settling time.

Top module: `perf_clk_sel`

## Requirements
- R1: After synchronous reset the control register is zero, which is best mode (code 0), and the processor domain takes the main PLL with exponent 0.
- R2: Mode codes are best=0, high=1, intermediate=2, low=3, low power=4. The processor divide exponent is 0, 1, 2, 4 for best, high, intermediate and low, all from the main PLL. In low power the processor takes the slow PLL with exponent 0.
- R3: Interconnect domain (index 1): exponent 2 for best and high, 3 for intermediate and 4 for low, all from the main PLL. In low power it takes the slow PLL with exponent 0.
- R4: Fast-bus domain (index 2): exponent 3 for best, high and intermediate, and 4 for low, all from the main PLL. In low power it takes the slow PLL with exponent 0.
- R5: Slow-bus domain (index 3): always the slow PLL with exponent 0, in every mode.
- R6: A mode-only write replaces bits [2:0] and leaves bits [15:3] unchanged. A mode-only write with a code of 5 to 7 changes nothing.
- R7: A full write stores bits [15:3]. It stores bits [2:0] only when they hold a legal code (0 to 4); otherwise the old mode is kept.
- R8: A rate request sets the mode by threshold and keeps bits [15:3]: at most 13 MHz gives low power, at most 52 gives intermediate, at most 104 gives high, and above 104 gives best.
- R9: When several writes arrive in one cycle, the rate request wins over the mode-only write, which wins over the full write. The losing writes are discarded.
- R10: Status bit 0 (lock) is 0 while in low power. Outside low power it equals the PLL lock input once LOCK_DLY cycles have passed since leaving low power. Status bit 1 is 1 exactly when the mode is low power. The other status bits are 0.
- R11: A write takes effect in the control register, the domain outputs and status bit 1 on the first clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Full control register write strobe |
| ctl_wdata | input | CTL_W | Full write data |
| mode_we | input | 1 | Mode-field-only write strobe |
| mode_wdata | input | 3 | Mode code for the mode-only write |
| rate_we | input | 1 | Processor rate request strobe |
| rate_mhz | input | RATE_W | Requested processor rate in MHz |
| pll_lock_in | input | 1 | Raw lock flag from the main PLL |
| ctl_q | output | CTL_W | Control register contents |
| status_q | output | CTL_W | Status word: bit 0 lock, bit 1 slow PLL in use |
| dom_from_slow | output | 4 | Per domain: 1 = slow PLL source |
| dom_div_log2 | output | 12 | Per domain 3-bit divide exponent, domain i at bits [3i+2:3i] |

## Verification
The hardest situation to reach is the settling window after low power is left. The lock bit must stay low for exactly LOCK_DLY cycles and then follow the PLL flag. A re-entry into low power, or a toggling PLL flag during the window, must not shorten it. The random stimulus makes low power common through rate requests at or below 13 MHz and toggles the PLL flag now and then. A directed sequence leaves low power, re-enters it partway through the window, and leaves it again, while every output is compared with a reference model on every cycle.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int MODE_W  = 3;
    localparam int DIV_W   = 3;
    localparam int NDOM    = 4;
    localparam int DOM_CPU = 0;
    localparam int DOM_ICN = 1;
    localparam int DOM_FST = 2;
    localparam int DOM_SLW = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_BEST = 3'd0,
        PM_HIGH = 3'd1,
        PM_MID  = 3'd2,
        PM_LOW  = 3'd3,
        PM_LP   = 3'd4
    } pmode_e;

    typedef struct packed {
        logic             from_slow;
        logic [DIV_W-1:0] div_log2;
    } dom_sel_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return m <= MODE_W'(PM_LP);
    endfunction

    function automatic pmode_e rate_to_mode(input int unsigned mhz);
        if (mhz <= 13)       return PM_LP;
        else if (mhz <= 52)  return PM_MID;
        else if (mhz <= 104) return PM_HIGH;
        else                 return PM_BEST;
    endfunction

    function automatic dom_sel_t dom_decode(input int dom, input pmode_e m);
        dom_sel_t s;
        s.from_slow = 1'b0;
        s.div_log2  = '0;
        if (m == PM_LP || dom == DOM_SLW) begin
            s.from_slow = 1'b1;
        end else begin
            case (dom)
                DOM_CPU: case (m)
                    PM_HIGH: s.div_log2 = 3'd1;
                    PM_MID:  s.div_log2 = 3'd2;
                    PM_LOW:  s.div_log2 = 3'd4;
                    default: s.div_log2 = 3'd0;
                endcase
                DOM_ICN: case (m)
                    PM_MID:  s.div_log2 = 3'd3;
                    PM_LOW:  s.div_log2 = 3'd4;
                    default: s.div_log2 = 3'd2;
                endcase
                default: s.div_log2 = (m == PM_LOW) ? 3'd4 : 3'd3;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pclk_ctl_reg.sv
module pclk_ctl_reg
    import pclk_pkg::*;
#(
    parameter int CTL_W  = 16,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_mhz,
    output logic [CTL_W-1:0]  ctl_q
);

    logic [CTL_W-1:0] ctl_nxt;

    always_comb begin
        ctl_nxt = ctl_q;
        if (rate_we) begin
            ctl_nxt[MODE_W-1:0] = rate_to_mode(int'(rate_mhz));
        end else if (mode_we) begin
            if (mode_legal(mode_wdata))
                ctl_nxt[MODE_W-1:0] = mode_wdata;
        end else if (ctl_we) begin
            ctl_nxt[CTL_W-1:MODE_W] = ctl_wdata[CTL_W-1:MODE_W];
            if (mode_legal(ctl_wdata[MODE_W-1:0]))
                ctl_nxt[MODE_W-1:0] = ctl_wdata[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_nxt;
    end

endmodule

// File: rtl/pclk_lock_track.sv
module pclk_lock_track #(
    parameter int LOCK_DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_lp,
    input  logic pll_lock_in,
    output logic lock_ind
);

    localparam int CNT_W = $clog2(LOCK_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_DLY);

    logic [CNT_W-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst)                  settle_cnt <= '0;
        else if (in_lp)           settle_cnt <= CNT_LOAD;
        else if (settle_cnt != 0) settle_cnt <= settle_cnt - 1'b1;
    end

    assign lock_ind = pll_lock_in && !in_lp && (settle_cnt == '0);

endmodule

// File: rtl/pclk_dom_decode.sv
module pclk_dom_decode
    import pclk_pkg::*;
(
    input  pmode_e                  mode,
    output logic [NDOM-1:0]         from_slow,
    output logic [NDOM*DIV_W-1:0]   div_log2
);

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        dom_sel_t sel;
        always_comb sel = dom_decode(d, mode);
        assign from_slow[d]                  = sel.from_slow;
        assign div_log2[d*DIV_W +: DIV_W]    = sel.div_log2;
    end

endmodule

// File: rtl/perf_clk_sel.sv
module perf_clk_sel
    import pclk_pkg::*;
#(
    parameter int CTL_W    = 16,
    parameter int RATE_W   = 8,
    parameter int LOCK_DLY = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ctl_we,
    input  logic [CTL_W-1:0]        ctl_wdata,
    input  logic                    mode_we,
    input  logic [2:0]              mode_wdata,
    input  logic                    rate_we,
    input  logic [RATE_W-1:0]       rate_mhz,
    input  logic                    pll_lock_in,
    output logic [CTL_W-1:0]        ctl_q,
    output logic [CTL_W-1:0]        status_q,
    output logic [3:0]              dom_from_slow,
    output logic [11:0]             dom_div_log2
);

    pmode_e cur_mode;
    logic   in_lp;
    logic   lock_ind;

    pclk_ctl_reg #(.CTL_W(CTL_W), .RATE_W(RATE_W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .rate_we    (rate_we),
        .rate_mhz   (rate_mhz),
        .ctl_q      (ctl_q)
    );

    assign cur_mode = pmode_e'(ctl_q[MODE_W-1:0]);
    assign in_lp    = (cur_mode == PM_LP);

    pclk_lock_track #(.LOCK_DLY(LOCK_DLY)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .in_lp       (in_lp),
        .pll_lock_in (pll_lock_in),
        .lock_ind    (lock_ind)
    );

    pclk_dom_decode u_dec (
        .mode      (cur_mode),
        .from_slow (dom_from_slow),
        .div_log2  (dom_div_log2)
    );

    always_comb begin
        status_q    = '0;
        status_q[0] = lock_ind;
        status_q[1] = in_lp;
    end

endmodule

// File: rtl/pclk_sel_chk.sv
module pclk_sel_chk #(
    parameter int CTL_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_we,
    input logic             rate_we,
    input logic             pll_lock_in,
    input logic [CTL_W-1:0] ctl_q,
    input logic [CTL_W-1:0] status_q,
    input logic [3:0]       dom_from_slow
);

    // R6
    mode_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_we || rate_we) |=> ctl_q[CTL_W-1:3] == $past(ctl_q[CTL_W-1:3]));

    // R10
    lp_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2:0] == 3'd4) |-> !status_q[0]);

    // R10
    lock_needs_pll_chk: assert property (@(posedge clk) disable iff (rst)
        status_q[0] |-> pll_lock_in);

    // R10
    lock_rise_not_after_lp_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_q[0]) && !$rose(pll_lock_in)) |-> $past(ctl_q[2:0]) != 3'd4);

    // R2
    lp_all_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2:0] == 3'd4) |-> dom_from_slow == 4'hF);

    // R5
    main_modes_src_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2:0] != 3'd4) |-> dom_from_slow == 4'b1000);

    // R7
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q[2:0] <= 3'd4);

endmodule

bind perf_clk_sel pclk_sel_chk #(.CTL_W(CTL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_we       (mode_we),
    .rate_we       (rate_we),
    .pll_lock_in   (pll_lock_in),
    .ctl_q         (ctl_q),
    .status_q      (status_q),
    .dom_from_slow (dom_from_slow)
);

// File: tb/perf_clk_sel_bench.sv
module perf_clk_sel_bench;

    localparam int CTL_W    = 16;
    localparam int RATE_W   = 8;
    localparam int LOCK_DLY = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_we = 1'b0;
    logic [CTL_W-1:0]  ctl_wdata = '0;
    logic              mode_we = 1'b0;
    logic [2:0]        mode_wdata = '0;
    logic              rate_we = 1'b0;
    logic [RATE_W-1:0] rate_mhz = '0;
    logic              pll_lock_in = 1'b1;
    logic [CTL_W-1:0]  ctl_q;
    logic [CTL_W-1:0]  status_q;
    logic [3:0]        dom_from_slow;
    logic [11:0]       dom_div_log2;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    logic [CTL_W-1:0] m_ctl = '0;
    int               m_cnt = 0;

    always #10 clk = ~clk;

    perf_clk_sel #(.CTL_W(CTL_W), .RATE_W(RATE_W), .LOCK_DLY(LOCK_DLY)) u_perf_clk_sel (
        .clk           (clk),
        .rst           (rst),
        .ctl_we        (ctl_we),
        .ctl_wdata     (ctl_wdata),
        .mode_we       (mode_we),
        .mode_wdata    (mode_wdata),
        .rate_we       (rate_we),
        .rate_mhz      (rate_mhz),
        .pll_lock_in   (pll_lock_in),
        .ctl_q         (ctl_q),
        .status_q      (status_q),
        .dom_from_slow (dom_from_slow),
        .dom_div_log2  (dom_div_log2)
    );

    function automatic int exp_div(input int m, input int d);
        if (m == 4 || d == 3) return 0;
        case (d)
            0: case (m) 1: return 1; 2: return 2; 3: return 4; default: return 0; endcase
            1: case (m) 2: return 3; 3: return 4; default: return 2; endcase
            default: return (m == 3) ? 4 : 3;
        endcase
    endfunction

    function automatic int exp_slow(input int m, input int d);
        return (m == 4 || d == 3) ? 1 : 0;
    endfunction

    function automatic int rate_mode(input int mhz);
        if (mhz <= 13)  return 4;
        if (mhz <= 52)  return 2;
        if (mhz <= 104) return 1;
        return 0;
    endfunction

    // reference update at each edge from the inputs stable since the last negedge
    always @(posedge clk) begin
        if (rst) begin
            m_ctl = '0;
            m_cnt = 0;
        end else begin
            if (m_ctl[2:0] == 3'd4) m_cnt = LOCK_DLY;
            else if (m_cnt > 0)     m_cnt = m_cnt - 1;
            if (rate_we) begin
                m_ctl[2:0] = 3'(rate_mode(int'(rate_mhz)));
            end else if (mode_we) begin
                if (mode_wdata <= 3'd4) m_ctl[2:0] = mode_wdata;
            end else if (ctl_we) begin
                m_ctl[CTL_W-1:3] = ctl_wdata[CTL_W-1:3];
                if (ctl_wdata[2:0] <= 3'd4) m_ctl[2:0] = ctl_wdata[2:0];
            end
        end
    end

    task automatic chk(input string tag, input int got, input int expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, expv);
        end
    endtask

    task automatic check_all();
        int m;
        logic [CTL_W-1:0] st;
        m = int'(m_ctl[2:0]);
        chk("R6 R7 R8 R9 R11 ctl_q", int'(ctl_q), int'(m_ctl));
        st = '0;
        st[1] = (m == 4);
        st[0] = pll_lock_in && (m != 4) && (m_cnt == 0);
        chk("R10 status_q", int'(status_q), int'(st));
        chk("R2 cpu div",  int'(dom_div_log2[2:0]),  exp_div(m, 0));
        chk("R2 cpu src",  int'(dom_from_slow[0]),   exp_slow(m, 0));
        chk("R3 icn div",  int'(dom_div_log2[5:3]),  exp_div(m, 1));
        chk("R3 icn src",  int'(dom_from_slow[1]),   exp_slow(m, 1));
        chk("R4 fast div", int'(dom_div_log2[8:6]),  exp_div(m, 2));
        chk("R4 fast src", int'(dom_from_slow[2]),   exp_slow(m, 2));
        chk("R5 slow div", int'(dom_div_log2[11:9]), 0);
        chk("R5 slow src", int'(dom_from_slow[3]),   1);
    endtask

    // one cycle: check at negedge, then drive the next inputs
    task automatic step(input bit cw, input int cd, input bit mw, input int md,
                        input bit rw, input int rd, input bit lk);
        @(negedge clk);
        check_all();
        ctl_we = cw; ctl_wdata = CTL_W'(cd);
        mode_we = mw; mode_wdata = 3'(md);
        rate_we = rw; rate_mhz = RATE_W'(rd);
        pll_lock_in = lk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk("R1 reset ctl", int'(ctl_q), 0);
        chk("R1 reset cpu div", int'(dom_div_log2[2:0]), 0);
        chk("R1 reset cpu src", int'(dom_from_slow[0]), 0);
        // R2 R3 R4 every mode in turn
        for (int md = 0; md < 5; md++) begin
            step(0, 0, 1, md, 0, 0, 1);
            idle(1);
        end
        // R6 illegal mode codes ignored; upper bits kept
        step(1, 16'hABC8 | 3, 0, 0, 0, 0, 1);
        step(0, 0, 1, 5, 0, 0, 1);
        step(0, 0, 1, 7, 0, 0, 1);
        step(0, 0, 1, 1, 0, 0, 1);
        // R7 full write with illegal mode keeps old mode
        step(1, 16'h5556 | 16'h0007, 0, 0, 0, 0, 1);
        idle(1);
        // R8 thresholds
        step(0, 0, 0, 0, 1, 13, 1);
        step(0, 0, 0, 0, 1, 14, 1);
        step(0, 0, 0, 0, 1, 52, 1);
        step(0, 0, 0, 0, 1, 53, 1);
        step(0, 0, 0, 0, 1, 104, 1);
        step(0, 0, 0, 0, 1, 105, 1);
        step(0, 0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 1, 255, 1);
        // R9 priority
        step(1, 16'hFFF0, 1, 3, 1, 60, 1);
        step(1, 16'h0F02, 1, 4, 0, 0, 1);
        step(1, 16'h0F02, 0, 0, 0, 0, 1);
        // R10 settling window, re-entry mid-window, PLL flag dropout
        step(0, 0, 1, 4, 0, 0, 1);
        step(0, 0, 1, 0, 0, 0, 1);
        idle(4);
        step(0, 0, 1, 4, 0, 0, 1);
        step(0, 0, 1, 0, 0, 0, 1);
        idle(LOCK_DLY + 2);
        step(0, 0, 0, 0, 0, 0, 0);
        idle(3);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            step(r == 0, int'($urandom_range(0, 65535)),
                 r == 1 || r == 2, int'($urandom_range(0, 7)),
                 r == 3, int'($urandom_range(0, 160)),
                 $urandom_range(0, 15) != 0);
        end
        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule